// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block times the high and low halves of the serial clock for an I2C master, counting in cycles of the peripheral clock. Software writes one configuration word that holds a divisor for the low half, a divisor for the high half and a shared power-of-two prescaler exponent. Each half lasts its divisor, shifted left by the exponent, plus a fixed build-time offset. Software computes the divisors; this block only counts them out. A 100 kHz bus is the usual target and 400 kHz is the fastest rate in scope.

The bit engine next to this block starts and stops clocking with a run request and may stretch a half with a hold input. The block drives the current clock level, a one-cycle pulse at the start of every phase and a one-cycle pulse in the middle of every phase, which the bit engine uses to sample data. Pad drivers are not part of this block.

Top module: `scl_wavegen`

## Requirements
- R1: A write with `cfg_we` stores the low-phase divisor from bits 7:0, the high-phase divisor from bits 15:8 and the exponent from bits 18:16. A low phase then lasts lo_div * 2^exp + OFFSET clocks and a high phase lasts hi_div * 2^exp + OFFSET clocks. All configuration fields reset to zero.
- R2: An exponent field above MAX_EXP (default 5) is used as MAX_EXP. With the default build, exponent values 6 and 7 therefore both give a factor of 32.
- R3: The length of a phase is fixed from the configuration held when that phase starts. A write during a phase leaves that phase's length unchanged and takes effect from the next phase.
- R4: While reset is asserted or `enable` is low, `scl_level` is 1 and neither tick is asserted. Dropping `enable` stops any phase, and `scl_level` is high in the following cycle. When `enable` is raised again, timing restarts from a full high phase.
- R5: While idle with `enable` high, `scl_level` stays 1 and no tick is asserted until `run` is sampled high. The first clock edge at which `run` is sampled high starts a high phase. After that, high and low phases alternate.
- R6: When `run` is sampled low, the current phase still completes. A low phase is followed by one full high phase. The block then rests idle with `scl_level` high and raises no further tick.
- R7: `edge_tick` is high for exactly one cycle: the first cycle of each phase, in which `scl_level` already shows the new phase's level.
- R8: `mid_tick` pulses once per phase, in cycle L - floor((L-1)/2) of a phase that is L cycles long. The first cycle of the phase is cycle 1.
- R9: While `hold` is high in an active phase, the phase counter is frozen and the phase is longer by the number of held cycles. `mid_tick` is not repeated during a hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master enable; low forces idle and clears the counter |
| run | input | 1 | Request from the bit engine to generate clock phases |
| hold | input | 1 | Stretch request; freezes the phase counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DATA_W | Configuration word (divisors and exponent) |
| scl_level | output | 1 | Current serial clock level |
| edge_tick | output | 1 | One-cycle pulse in the first cycle of each phase |
| mid_tick | output | 1 | One-cycle pulse in the middle of each phase |

## Verification
The bench measures phase lengths by counting cycles between `edge_tick` pulses. It uses configuration words that set each field's top and bottom bits and exponents on both sides of the cap. A wrong field slice, a shift that is not applied, or a missing cap shows up as a count that is off by a factor of two or more. A configuration write made halfway through a high phase must not change that phase. A design that reloads or recomputes the phase immediately would cut it to three cycles. The bench also holds the counter in a low phase, drops `run` during a low phase, and drops `enable` during a phase. A wrong design would, respectively, lengthen the phase by the wrong amount or pulse `mid_tick` twice, end the transfer with the clock stuck low, or leave the clock low or ticking after it has been disabled.

// File: rtl/scg_pkg.sv
package scg_pkg;

   // state of the clock phase sequencer
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HIGH = 2'd1,
      PH_LOW  = 2'd2
   } phase_e;

endpackage

// File: rtl/scg_cfg_decode.sv
module scg_cfg_decode #(
   parameter int DATA_W  = 32,
   parameter int DIV_W   = 8,
   parameter int EXP_W   = 3,
   parameter int MAX_EXP = 5,
   parameter int OFFSET  = 3,
   parameter int CNT_W   = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              sel_high,
   output logic [CNT_W-1:0]  len_m1,
   output logic [CNT_W-1:0]  mid_pt
);

   localparam int LO_LSB  = 0;
   localparam int HI_LSB  = DIV_W;
   localparam int EXP_LSB = 2 * DIV_W;
   localparam int FIELD_W = EXP_LSB + EXP_W;
   localparam int EXP_TOP = (1 << EXP_W) - 1;

   logic [DIV_W-1:0] lo_q;
   logic [DIV_W-1:0] hi_q;
   logic [EXP_W-1:0] exp_q;
   logic [EXP_W-1:0] exp_eff;
   logic [CNT_W-1:0] len;

   // shadow copy of the configuration word; consumed only at phase loads
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         exp_q <= '0;
      end else if (cfg_we) begin
         lo_q  <= cfg_wdata[LO_LSB  +: DIV_W];
         hi_q  <= cfg_wdata[HI_LSB  +: DIV_W];
         exp_q <= cfg_wdata[EXP_LSB +: EXP_W];
      end
   end

   generate
      if (MAX_EXP >= EXP_TOP) begin : g_nocap
         assign exp_eff = exp_q;
      end else begin : g_cap
         assign exp_eff = (exp_q > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_q;
      end

      if (DATA_W > FIELD_W) begin : g_spare
         logic unused_spare;
         assign unused_spare = ^cfg_wdata[DATA_W-1:FIELD_W];
      end
   endgenerate

   always_comb begin
      len    = (CNT_W'(sel_high ? hi_q : lo_q) << exp_eff) + CNT_W'(OFFSET);
      len_m1 = len - CNT_W'(1);
      mid_pt = len_m1 >> 1;
   end

   // R2
   exp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exp_eff <= EXP_W'(MAX_EXP));

endmodule

// File: rtl/scg_phase_timer.sv
module scg_phase_timer #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] load_mid,
   input  logic             dec,
   output logic             at_zero,
   output logic             mid_tick
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] mid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         mid_q    <= '0;
         mid_tick <= 1'b0;
      end else if (clr) begin
         cnt      <= '0;
         mid_q    <= '0;
         mid_tick <= 1'b0;
      end else if (load) begin
         cnt      <= load_val;
         mid_q    <= load_mid;
         mid_tick <= 1'b0;
      end else if (dec && cnt != '0) begin
         cnt      <= cnt - CNT_W'(1);
         mid_tick <= (cnt == mid_q + CNT_W'(1));
      end else begin
         mid_tick <= 1'b0;
      end
   end

   assign at_zero = (cnt == '0);

   // R1
   load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (cnt == $past(load_val)));

   // R9
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !dec) |=> $stable(cnt));

   // R8
   mid_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mid_tick |=> !mid_tick);

endmodule

// File: rtl/scg_level_fsm.sv
module scg_level_fsm
   import scg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic run,
   input  logic hold,
   input  logic at_zero,
   output logic clr,
   output logic load,
   output logic dec,
   output logic sel_high,
   output logic scl_level,
   output logic edge_tick
);

   phase_e state;
   phase_e nxt;
   logic   tick_n;

   always_comb begin
      nxt      = state;
      clr      = 1'b0;
      load     = 1'b0;
      sel_high = 1'b1;
      tick_n   = 1'b0;
      if (!enable) begin
         nxt = PH_IDLE;
         clr = 1'b1;
      end else begin
         case (state)
            PH_IDLE: begin
               if (run) begin
                  nxt    = PH_HIGH;
                  load   = 1'b1;
                  tick_n = 1'b1;
               end
            end
            PH_HIGH: begin
               if (at_zero && !hold) begin
                  if (run) begin
                     nxt      = PH_LOW;
                     load     = 1'b1;
                     sel_high = 1'b0;
                     tick_n   = 1'b1;
                  end else begin
                     nxt = PH_IDLE;
                     clr = 1'b1;
                  end
               end
            end
            PH_LOW: begin
               if (at_zero && !hold) begin
                  nxt    = PH_HIGH;
                  load   = 1'b1;
                  tick_n = 1'b1;
               end
            end
            default: begin
               nxt = PH_IDLE;
               clr = 1'b1;
            end
         endcase
      end
      dec = (state != PH_IDLE) && enable && !hold && !load;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PH_IDLE;
         scl_level <= 1'b1;
         edge_tick <= 1'b0;
      end else begin
         state     <= nxt;
         scl_level <= (nxt != PH_LOW);
         edge_tick <= tick_n;
      end
   end

   // R4
   disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (scl_level && !edge_tick));

   // R7
   low_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_tick && !scl_level) |-> $past(scl_level));

   // R6
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PH_IDLE) |-> scl_level);

   // R5
   start_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == PH_IDLE && state == PH_HIGH) |-> edge_tick);

endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen #(
   parameter int DATA_W     = 32,
   parameter int DIV_W      = 8,
   parameter int EXP_W      = 3,
   parameter int MAX_EXP    = 5,
   parameter int OFFSET     = 3,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              run,
   input  logic              hold,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              scl_level,
   output logic              edge_tick,
   output logic              mid_tick
);

   localparam int CNT_W = DIV_W + MAX_EXP + 1;

   generate
      if (MAX_EXP < 0 || MAX_EXP > (1 << EXP_W) - 1) begin : g_bad_exp
         $error("MAX_EXP must fit the exponent field");
      end
      if (OFFSET < 2 || OFFSET >= (1 << (DIV_W + MAX_EXP))) begin : g_bad_off
         $error("OFFSET out of range");
      end
      if (DATA_W < 2 * DIV_W + EXP_W) begin : g_bad_data
         $error("DATA_W too narrow for the configuration fields");
      end
   endgenerate

   logic             hold_eff;
   logic             clr;
   logic             load;
   logic             dec;
   logic             sel_high;
   logic             at_zero;
   logic [CNT_W-1:0] len_m1;
   logic [CNT_W-1:0] mid_pt;

   generate
      if (STRETCH_EN) begin : g_stretch
         assign hold_eff = hold;
      end else begin : g_nostretch
         assign hold_eff = 1'b0;
      end
   endgenerate

   scg_cfg_decode #(
      .DATA_W (DATA_W),
      .DIV_W  (DIV_W),
      .EXP_W  (EXP_W),
      .MAX_EXP(MAX_EXP),
      .OFFSET (OFFSET),
      .CNT_W  (CNT_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .sel_high (sel_high),
      .len_m1   (len_m1),
      .mid_pt   (mid_pt)
   );

   scg_phase_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .load    (load),
      .load_val(len_m1),
      .load_mid(mid_pt),
      .dec     (dec),
      .at_zero (at_zero),
      .mid_tick(mid_tick)
   );

   scg_level_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .run      (run),
      .hold     (hold_eff),
      .at_zero  (at_zero),
      .clr      (clr),
      .load     (load),
      .dec      (dec),
      .sel_high (sel_high),
      .scl_level(scl_level),
      .edge_tick(edge_tick)
   );

endmodule

// File: tb/sim_scl_wavegen.sv
module sim_scl_wavegen;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   // {config word, expected high length, expected low length}
   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0000_140A, 16'd23,  16'd13},
      {32'h0002_0201, 16'd11,  16'd7},
      {32'h0000_0000, 16'd3,   16'd3},
      {32'h0007_0103, 16'd35,  16'd99},
      {32'h0005_0202, 16'd67,  16'd67},
      {32'h0006_0001, 16'd3,   16'd35},
      {32'h0000_FFFF, 16'd258, 16'd258},
      {32'h0001_0180, 16'd5,   16'd259}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        run = 1'b0;
   logic        hold = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        scl_level;
   logic        edge_tick;
   logic        mid_tick;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   scl_wavegen u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .run      (run),
      .hold     (hold),
      .cfg_we   (cfg_we),
      .cfg_wdata(cfg_wdata),
      .scl_level(scl_level),
      .edge_tick(edge_tick),
      .mid_tick (mid_tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [31:0] w);
      cfg_we    = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic idle_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // wait for the tick that opens a high phase
   task automatic wait_start();
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!(edge_tick === 1'b1 && scl_level === 1'b1) && guard < 20000);
   endtask

   // count cycles of the current phase until the next edge_tick
   task automatic count_phase(input int first, output int n);
      n = first;
      forever begin
         @(negedge clk);
         if (edge_tick === 1'b1 || n > 20000) break;
         n++;
      end
   endtask

   task automatic measure(input int hold_at, input int hold_len,
                          output int hi, output int lo,
                          output int hmid, output int lmids);
      hmid  = 0;
      lmids = 0;
      wait_start();
      hi = 1;
      if (mid_tick) hmid = 1;
      forever begin
         @(negedge clk);
         if (edge_tick === 1'b1 || hi > 20000) break;
         hi++;
         if (mid_tick) hmid = hi;
      end
      lo    = 1;
      lmids = int'(mid_tick);
      forever begin
         if (hold_len > 0 && lo == hold_at) hold = 1'b1;
         if (lo == hold_at + hold_len) hold = 1'b0;
         @(negedge clk);
         if (edge_tick === 1'b1 || lo > 20000) break;
         lo++;
         lmids += int'(mid_tick);
      end
      hold = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int hi, lo, hmid, lmids, n, ticks, lows;

      // reset state (R4)
      idle_wait(3);
      chk(scl_level === 1'b1, "R4 reset scl_level", int'(scl_level), 1);
      chk(edge_tick === 1'b0 && mid_tick === 1'b0, "R4 reset ticks",
          int'(edge_tick) + int'(mid_tick), 0);
      rst_n = 1'b1;

      // enabled but no run request: nothing happens (R5)
      enable = 1'b1;
      ticks = 0;
      lows  = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         ticks += int'(edge_tick) + int'(mid_tick);
         lows  += int'(!scl_level);
      end
      chk(ticks == 0 && lows == 0, "R5 idle without run", ticks + lows, 0);

      // run while disabled: still quiet (R4)
      enable = 1'b0;
      run    = 1'b1;
      ticks  = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         ticks += int'(edge_tick) + int'(!scl_level);
      end
      chk(ticks == 0, "R4 run while disabled", ticks, 0);
      run    = 1'b0;
      enable = 1'b1;

      // table of configurations (R1, R2, R8)
      for (int v = 0; v < NVEC; v++) begin
         int ehi, elo;
         ehi = int'(VEC[v][31:16]);
         elo = int'(VEC[v][15:0]);
         run = 1'b0;
         idle_wait(600);
         write_cfg(VEC[v][63:32]);
         run = 1'b1;
         measure(0, 0, hi, lo, hmid, lmids);
         chk(hi == ehi, $sformatf("R1/R2 vec%0d high length", v), hi, ehi);
         chk(lo == elo, $sformatf("R1/R2 vec%0d low length", v), lo, elo);
         chk(hmid == ehi - (ehi - 1) / 2, $sformatf("R8 vec%0d mid position", v),
             hmid, ehi - (ehi - 1) / 2);
         chk(lmids == 1, $sformatf("R8 vec%0d mid count", v), lmids, 1);
         chk(scl_level === 1'b1, $sformatf("R7 vec%0d tick opens high", v),
             int'(scl_level), 1);
      end

      // config write in the middle of a high phase (R3)
      run = 1'b0;
      idle_wait(600);
      write_cfg(32'h0000_140A);
      run = 1'b1;
      wait_start();
      write_cfg(32'h0000_0000);
      count_phase(2, n);
      chk(n == 23, "R3 running high phase kept", n, 23);
      chk(scl_level === 1'b0, "R7 low phase level", int'(scl_level), 0);
      count_phase(1, n);
      chk(n == 3, "R3 new config on next phase", n, 3);

      // stretch in a low phase (R9)
      run = 1'b0;
      idle_wait(100);
      write_cfg(32'h0000_140A);
      run = 1'b1;
      measure(3, 7, hi, lo, hmid, lmids);
      chk(lo == 20, "R9 stretched low length", lo, 20);
      chk(lmids == 1, "R9 single mid tick while held", lmids, 1);

      // stop during a low phase (R6)
      run = 1'b0;
      idle_wait(100);
      run = 1'b1;
      wait_start();
      count_phase(1, n);
      @(negedge clk);
      run = 1'b0;
      count_phase(2, n);
      chk(n == 13, "R6 low phase completes", n, 13);
      chk(scl_level === 1'b1, "R6 closing high phase", int'(scl_level), 1);
      ticks = 0;
      lows  = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         ticks += int'(edge_tick);
         lows  += int'(!scl_level);
      end
      chk(ticks == 0 && lows == 0, "R6 rests high after stop", ticks + lows, 0);

      // drop enable inside a low phase (R4)
      run = 1'b1;
      wait_start();
      count_phase(1, n);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(scl_level === 1'b1 && edge_tick === 1'b0, "R4 disable aborts phase",
          int'(scl_level), 1);
      ticks = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         ticks += int'(edge_tick) + int'(!scl_level);
      end
      chk(ticks == 0, "R4 quiet while disabled", ticks, 0);
      enable = 1'b1;
      measure(0, 0, hi, lo, hmid, lmids);
      chk(hi == 23, "R4 fresh high phase after enable", hi, 23);
      chk(lo == 13, "R5 alternation resumes", lo, 13);

      run = 1'b0;
      idle_wait(5);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule